// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block owns the mode register of an analog PLL and brings the PLL up and down in a safe order. Software, or a neighbouring controller, loads the register image through a one-cycle write port and starts work with single-cycle request pulses: enable, disable, re-program with a new divider value, or configure the external vote mode. The sequencer then steps the register's control bits itself. It clears bypass first. It waits a settle time counted in microseconds, then releases the PLL reset. It then polls a lock-status input once per microsecond and turns the output on as soon as lock is seen.

The microsecond time base comes from a prescaler sized by the input clock frequency in MHz. When lock does not arrive within a bounded number of polls, the sequence ends with a timeout pulse and the output stays off. When vote mode is enabled, an external agent owns the PLL, so enable and disable requests finish at once and change nothing. A busy output is high while a multi-cycle sequence runs, and the block ignores every request and write that arrives during that time.

Top module: `pllctl_seq`

## Requirements
- R1: After reset the mode register reads 22'h200000 (only the vote-machine reset bit set), the divider reads 0, and busy, done and timeout are low.
- R2: Mode register layout: bit 0 output enable, bit 1 bypass-off (1 = not bypassed), bit 2 PLL reset release (active-low reset, 1 = running), bits 13:8 lock count, bits 19:14 bias count, bit 20 vote enable, bit 21 vote-machine reset. When the block is idle and no request is present, wr_en loads the whole 22-bit wr_data image at that edge.
- R3: An accepted enable sets bypass-off and busy at the accepting edge. It releases the PLL reset exactly SETTLE_US*CLK_MHZ cycles later. Output enable is set only after the reset release.
- R4: After the reset release, lock_i is sampled once every CLK_MHZ cycles. At the first sample that finds it high, output enable is set, done pulses for one cycle and busy drops, all at that edge.
- R5: If LOCK_TRIES samples in a row find no lock, timeout pulses for one cycle, busy drops, and output enable stays 0 while bits 2:1 stay 1.
- R6: An enable request made when bits 2:0 are all 1, or when vote enable is set, pulses done one cycle later, leaves the register unchanged and never raises busy.
- R7: A disable request clears bits 2:0 in one edge and pulses done. If vote enable is set, it changes nothing and still pulses done.
- R8: A re-program request made while bits 2:0 are all 1 (vote off) does three things. At the accepting edge it clears bits 2:0 and loads prog_div. At the next edge it starts the enable sequence of R3 and R4, one cycle later than a plain enable.
- R9: A re-program request made while the PLL is not fully enabled, or while vote mode is on, loads prog_div, pulses done one cycle later, and leaves the control bits alone.
- R10: A vote-configure request takes three consecutive edges. The first clears bit 21. The second writes bias count 1 and a lock count of 8 (or 0 when vote_lp is high). The third sets bit 20 and pulses done.
- R11: While busy is high, all requests and writes are ignored: the register, the divider and the sequence timing are unaffected.
- R12: When several requests arrive together, enable wins over disable, disable over re-program, and re-program over vote-configure. A write in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load wr_data into the mode register |
| wr_data | input | 22 | Mode register image |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| prog_req | input | 1 | Re-program request pulse |
| prog_div | input | DIV_W | New divider value for re-program |
| vote_req | input | 1 | Vote-configure request pulse |
| vote_lp | input | 1 | Selects the low-power lock count for vote-configure |
| lock_i | input | 1 | PLL lock status |
| mode_q | output | 22 | Current mode register |
| div_q | output | DIV_W | Current divider value |
| busy | output | 1 | A multi-cycle sequence is running |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle lock timeout pulse |

## Verification
The hardest case to reach from the ports is the phase of the lock arrival relative to the free-running microsecond tick. That phase decides which poll sees lock first, so the lock model is delayed by every cycle count from 0 to 13, and each run's completion edge is checked against the tick arithmetic. Requests that land in the middle of a settle window are the other hard case. The bench injects a disable, a re-program and a write on a known cycle inside that window, then checks that the control bits, the divider and the final completion time are untouched.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

  localparam int MODE_W  = 22;
  localparam int B_OUT   = 0;
  localparam int B_BYP   = 1;
  localparam int B_RSTN  = 2;
  localparam int CNT_W   = 6;
  localparam int LCK_LO  = 8;
  localparam int BIAS_LO = LCK_LO + CNT_W;
  localparam int B_VEN   = BIAS_LO + CNT_W;
  localparam int B_VRST  = B_VEN + 1;
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(1) << B_VRST;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESTART,
    ST_SETTLE,
    ST_LOCK,
    ST_VCNT,
    ST_VENA
  } seq_st_t;

  typedef struct packed {
    logic [MODE_W-1:0] set_m;
    logic [MODE_W-1:0] clr_m;
  } mode_op_t;

endpackage

// File: rtl/pllctl_us_tick.sv
module pllctl_us_tick #(
  parameter int CLK_MHZ = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(CLK_MHZ + 1);
  localparam logic [CW-1:0] LAST = CW'(CLK_MHZ - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    if (restart || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (CLK_MHZ > 1) begin : g_spacing
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/pllctl_seq_fsm.sv
module pllctl_seq_fsm
  import pllctl_pkg::*;
#(
  parameter int SETTLE_US    = 10,
  parameter int LOCK_TRIES   = 200,
  parameter int LOCK_CNT_STD = 8,
  parameter int LOCK_CNT_LP  = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_req,
  input  logic     dis_req,
  input  logic     prog_req,
  input  logic     vote_req,
  input  logic     vote_lp,
  input  logic     lock_i,
  input  logic     tick,
  input  logic [2:0] ctl_bits,
  input  logic     vote_on,
  input  logic     vote_rst,
  output mode_op_t op,
  output logic     div_ld,
  output logic     wr_ok,
  output logic     tick_restart,
  output logic     busy,
  output logic     done,
  output logic     timeout
);
  localparam int MAXC = (SETTLE_US > LOCK_TRIES) ? SETTLE_US : LOCK_TRIES;
  localparam int UW   = $clog2(MAXC + 1);
  localparam logic [UW-1:0] SET_LAST  = UW'(SETTLE_US - 1);
  localparam logic [UW-1:0] TRY_LAST  = UW'(LOCK_TRIES - 1);
  localparam logic [UW-1:0] TRY_LIMIT = UW'(LOCK_TRIES);

  seq_st_t       st_q, st_d;
  logic [UW-1:0] us_q, us_d;
  logic          lp_q, lp_d;
  logic          done_q, done_d;
  logic          to_q, to_d;
  logic          all_on;

  assign all_on = &ctl_bits;

  always_comb begin
    st_d         = st_q;
    us_d         = us_q;
    lp_d         = lp_q;
    done_d       = 1'b0;
    to_d         = 1'b0;
    op           = '0;
    div_ld       = 1'b0;
    wr_ok        = 1'b0;
    tick_restart = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en_req) begin
          if (all_on || vote_on) begin
            done_d = 1'b1;
          end else begin
            op.set_m[B_BYP] = 1'b1;
            tick_restart    = 1'b1;
            us_d            = '0;
            st_d            = ST_SETTLE;
          end
        end else if (dis_req) begin
          done_d = 1'b1;
          if (!vote_on) op.clr_m[B_RSTN:B_OUT] = '1;
        end else if (prog_req) begin
          div_ld = 1'b1;
          if (all_on && !vote_on) begin
            op.clr_m[B_RSTN:B_OUT] = '1;
            st_d = ST_RESTART;
          end else begin
            done_d = 1'b1;
          end
        end else if (vote_req) begin
          op.clr_m[B_VRST] = 1'b1;
          lp_d = vote_lp;
          st_d = ST_VCNT;
        end else begin
          wr_ok = 1'b1;
        end
      end
      ST_RESTART: begin
        op.set_m[B_BYP] = 1'b1;
        tick_restart    = 1'b1;
        us_d            = '0;
        st_d            = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (tick) begin
          if (us_q == SET_LAST) begin
            op.set_m[B_RSTN] = 1'b1;
            us_d = '0;
            st_d = ST_LOCK;
          end else begin
            us_d = us_q + UW'(1);
          end
        end
      end
      ST_LOCK: begin
        if (tick) begin
          if (lock_i) begin
            op.set_m[B_OUT] = 1'b1;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (us_q == TRY_LAST) begin
            to_d = 1'b1;
            st_d = ST_IDLE;
          end else begin
            us_d = us_q + UW'(1);
          end
        end
      end
      ST_VCNT: begin
        op.clr_m[LCK_LO +: 2*CNT_W] = '1;
        op.set_m[BIAS_LO +: CNT_W]  = CNT_W'(1);
        op.set_m[LCK_LO +: CNT_W]   = lp_q ? CNT_W'(LOCK_CNT_LP) : CNT_W'(LOCK_CNT_STD);
        st_d = ST_VENA;
      end
      ST_VENA: begin
        op.set_m[B_VEN] = 1'b1;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      us_q   <= '0;
      lp_q   <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      us_q   <= us_d;
      lp_q   <= lp_d;
      done_q <= done_d;
      to_q   <= to_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign timeout = to_q;

  p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |-> (us_q < TRY_LIMIT));
  p_timeout_from_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> ($past(st_q) == ST_LOCK));
  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && to_q));
  p_vote_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_VENA) |-> !vote_rst);

endmodule

// File: rtl/pllctl_mode_reg.sv
module pllctl_mode_reg
  import pllctl_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  mode_op_t          op,
  input  logic              div_ld,
  input  logic [DIV_W-1:0]  div_in,
  output logic [MODE_W-1:0] mode_q,
  output logic [DIV_W-1:0]  div_q
);
  logic              wr_hit;
  logic              mode_ce;
  logic [MODE_W-1:0] mode_d;

  assign wr_hit  = wr_ok && wr_en;
  assign mode_ce = wr_hit || (|op.set_m) || (|op.clr_m);

  always_comb begin
    if (wr_hit) mode_d = wr_data;
    else        mode_d = (mode_q & ~op.clr_m) | op.set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_ce) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_ld) div_q <= div_in;
  end

  p_rst_after_byp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mode_q[B_RSTN]) && !$past(wr_hit)) |-> mode_q[B_BYP]);
  p_out_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mode_q[B_OUT]) && !$past(wr_hit)) |-> (mode_q[B_RSTN] && mode_q[B_BYP]));

endmodule

// File: rtl/pllctl_seq.sv
module pllctl_seq
  import pllctl_pkg::*;
#(
  parameter int CLK_MHZ      = 200,
  parameter int SETTLE_US    = 10,
  parameter int LOCK_TRIES   = 200,
  parameter int DIV_W        = 10,
  parameter int LOCK_CNT_STD = 8,
  parameter int LOCK_CNT_LP  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              prog_req,
  input  logic [DIV_W-1:0]  prog_div,
  input  logic              vote_req,
  input  logic              vote_lp,
  input  logic              lock_i,
  output logic [MODE_W-1:0] mode_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  mode_op_t op;
  logic     div_ld;
  logic     wr_ok;
  logic     tick_restart;
  logic     tick;

  pllctl_us_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tick_restart),
    .tick    (tick)
  );

  pllctl_seq_fsm #(
    .SETTLE_US    (SETTLE_US),
    .LOCK_TRIES   (LOCK_TRIES),
    .LOCK_CNT_STD (LOCK_CNT_STD),
    .LOCK_CNT_LP  (LOCK_CNT_LP)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_req       (en_req),
    .dis_req      (dis_req),
    .prog_req     (prog_req),
    .vote_req     (vote_req),
    .vote_lp      (vote_lp),
    .lock_i       (lock_i),
    .tick         (tick),
    .ctl_bits     (mode_q[B_RSTN:B_OUT]),
    .vote_on      (mode_q[B_VEN]),
    .vote_rst     (mode_q[B_VRST]),
    .op           (op),
    .div_ld       (div_ld),
    .wr_ok        (wr_ok),
    .tick_restart (tick_restart),
    .busy         (busy),
    .done         (done),
    .timeout      (timeout)
  );

  pllctl_mode_reg #(.DIV_W(DIV_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .op      (op),
    .div_ld  (div_ld),
    .div_in  (prog_div),
    .mode_q  (mode_q),
    .div_q   (div_q)
  );

endmodule

// File: tb/pllctl_seq_bench.sv
module pllctl_seq_bench;
  localparam int P = 4;
  localparam int S = 10;
  localparam int T = 200;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [21:0] wr_data = '0;
  logic en_req = 1'b0, dis_req = 1'b0, prog_req = 1'b0, vote_req = 1'b0, vote_lp = 1'b0;
  logic [DW-1:0] prog_div = '0;
  logic lock_i = 1'b0;
  logic [21:0] mode_q;
  logic [DW-1:0] div_q;
  logic busy, done, timeout;

  int total = 0;
  int bad = 0;
  int lock_delay = 0;
  int lc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pllctl_seq #(.CLK_MHZ(P), .SETTLE_US(S), .LOCK_TRIES(T), .DIV_W(DW)) u_pllctl_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_req(en_req), .dis_req(dis_req), .prog_req(prog_req), .prog_div(prog_div),
    .vote_req(vote_req), .vote_lp(vote_lp), .lock_i(lock_i),
    .mode_q(mode_q), .div_q(div_q), .busy(busy), .done(done), .timeout(timeout)
  );

  // lock model: rises lock_delay cycles after the reset release is seen
  always @(negedge clk) begin
    if (mode_q[2] !== 1'b1) begin
      lc <= 0;
      lock_i <= 1'b0;
    end else begin
      if (lc >= lock_delay) lock_i <= 1'b1;
      lc <= lc + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic req(input logic e, input logic d, input logic p, input logic v,
                     input logic w, input logic [21:0] wd, input logic [DW-1:0] pd,
                     input logic lp);
    @(negedge clk);
    en_req = e; dis_req = d; prog_req = p; vote_req = v; wr_en = w;
    wr_data = wd; prog_div = pd; vote_lp = lp;
    @(posedge clk);
    #1;
    en_req = 0; dis_req = 0; prog_req = 0; vote_req = 0; wr_en = 0;
  endtask

  // observes cycles n=1.. after the accepting edge; base=1 for re-program
  task automatic watch(input int base, input int dly, input int inj, input string tg);
    int n_rst, n_done, n_to, j;
    logic [DW-1:0] div0;
    n_rst = -1; n_done = -1; n_to = -1;
    div0 = div_q;
    for (int n = 1; n <= 3000; n++) begin
      @(negedge clk);
      if (n_rst < 0 && mode_q[2]) n_rst = n;
      if (done && n_done < 0) n_done = n;
      if (timeout && n_to < 0) n_to = n;
      if (base == 1 && n == 1) check({"R8 clear ", tg}, {29'd0, mode_q[2:0]}, 32'd0);
      if (n == base + 1) check({"R3 bypass-off first ", tg}, {30'd0, mode_q[2:1], busy}, 32'b011);
      if (inj > 0 && n == inj + 1) begin
        check("R11 ctl bits kept", {29'd0, mode_q[2:0]}, 32'b010);
        check("R11 div kept", {22'd0, div_q}, {22'd0, div0});
      end
      if (n_done > 0 || n_to > 0) break;
      if (inj > 0 && n == inj) begin
        dis_req = 1; prog_req = 1; prog_div = ~div_q; wr_en = 1; wr_data = '1;
        @(posedge clk);
        #1;
        dis_req = 0; prog_req = 0; wr_en = 0;
      end
    end
    check({"R3 reset release time ", tg}, n_rst, base + S*P + 1);
    j = (dly + P) / P;
    if (j <= T) begin
      check({"R4 done time ", tg}, n_done, base + (S + j)*P + 1);
      check({"R4 output on ", tg}, {31'd0, mode_q[0]}, 32'd1);
    end else begin
      check("R5 timeout time", n_to, base + (S + T)*P + 1);
      check("R5 state after timeout", {28'd0, mode_q[2:0], busy}, 32'b1100);
    end
  endtask

  task automatic disable_chk;
    req(0, 1, 0, 0, 0, '0, '0, 0);
    @(negedge clk);
    check("R7 disable clears", {28'd0, mode_q[2:0], done}, 32'b0001);
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode reset", {10'd0, mode_q}, 32'h200000);
    check("R1 div reset", {22'd0, div_q}, 32'd0);
    check("R1 flags reset", {29'd0, busy, done, timeout}, 32'd0);

    // R2 write port
    req(0, 0, 0, 0, 1, 22'h0A5A5A, '0, 0); @(negedge clk);
    check("R2 write a", {10'd0, mode_q}, 32'h0A5A5A);
    req(0, 0, 0, 0, 1, 22'h15A5A0, '0, 0); @(negedge clk);
    check("R2 write b", {10'd0, mode_q}, 32'h15A5A0);
    req(0, 0, 0, 0, 1, 22'h000000, '0, 0); @(negedge clk);
    check("R2 write c", {10'd0, mode_q}, 32'h0);

    // R9 re-program while off
    req(0, 0, 1, 0, 0, '0, 10'h155, 0); @(negedge clk);
    check("R9 div load", {22'd0, div_q}, 32'h155);
    check("R9 ctl unchanged and done", {28'd0, mode_q[2:0], done}, 32'b0001);

    // R3/R4 sweep of lock phase
    for (int d = 0; d < 14; d++) begin
      lock_delay = d;
      req(1, 0, 0, 0, 0, '0, '0, 0);
      watch(0, d, 0, "sweep");
      disable_chk();
    end

    // R6 already enabled
    lock_delay = 0;
    req(1, 0, 0, 0, 0, '0, '0, 0);
    watch(0, 0, 0, "pre-R6");
    req(1, 0, 0, 0, 0, '0, '0, 0); @(negedge clk);
    check("R6 already on", {28'd0, mode_q[2:0], done}, 32'b1111);
    check("R6 no busy", {31'd0, busy}, 32'd0);

    // R8 re-program while on
    lock_delay = 3;
    req(0, 0, 1, 0, 0, '0, 10'h2AA, 0);
    watch(1, 3, 0, "reprog");
    check("R8 div loaded", {22'd0, div_q}, 32'h2AA);
    disable_chk();

    // R11 requests mid-sequence ignored
    lock_delay = 5;
    req(1, 0, 0, 0, 0, '0, '0, 0);
    watch(0, 5, 4, "inject");
    disable_chk();

    // R5 timeout
    lock_delay = 1000000;
    req(1, 0, 0, 0, 0, '0, '0, 0);
    watch(0, 1000000, 0, "timeout");
    disable_chk();

    // R12 priority
    lock_delay = 0;
    req(1, 1, 1, 1, 1, 22'h3FFFFF, 10'h011, 0); @(negedge clk);
    check("R12 enable wins, write dropped", {10'd0, mode_q}, 32'h000002);
    check("R12 busy", {31'd0, busy}, 32'd1);
    check("R12 div untouched", {22'd0, div_q}, 32'h2AA);
    repeat (S*P + P + 2) @(negedge clk);
    check("R12 sequence completes", {29'd0, mode_q[2:0]}, 32'b111);
    disable_chk();

    // R10 vote configure
    req(0, 0, 0, 0, 1, 22'h2FFF00, '0, 0); @(negedge clk);
    req(0, 0, 0, 1, 0, '0, '0, 0);
    @(negedge clk);
    check("R10 step1 vote reset off", {30'd0, mode_q[21], busy}, 32'b01);
    @(negedge clk);
    check("R10 step2 counts", {10'd0, mode_q}, 32'h004800);
    @(negedge clk);
    check("R10 step3 vote on", {10'd0, mode_q}, 32'h104800);
    check("R10 done", {30'd0, done, busy}, 32'b10);

    // R6/R7 vote mode suppression
    req(1, 0, 0, 0, 0, '0, '0, 0); @(negedge clk);
    check("R6 vote enable no change", {10'd0, mode_q}, 32'h104800);
    check("R6 vote done", {30'd0, done, busy}, 32'b10);
    req(0, 0, 0, 0, 1, 22'h104807, '0, 0); @(negedge clk);
    req(0, 1, 0, 0, 0, '0, '0, 0); @(negedge clk);
    check("R7 vote disable no change", {10'd0, mode_q}, 32'h104807);
    check("R7 vote done", {31'd0, done}, 32'd1);

    // R10 low-power lock count
    req(0, 0, 0, 1, 0, '0, '0, 1);
    repeat (3) @(negedge clk);
    check("R10 low-power count", {10'd0, mode_q}, 32'h104007);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule